// File: doc/BRIEF.md
# Byte-Wide BCD Calendar Register Bank

This block keeps calendar time (seconds through year, plus a century flag) in BCD and exposes it to a host as eight byte registers at the very top of a byte-addressed memory space. Live counters advance on a one-cycle 1 Hz enable pulse. The host never reads the live counters directly. It reads a bank of holding registers that copy the counters every clock while no freeze is requested. Addresses below the register window are passed out as a select for an external memory.

A control byte at the lowest address of the window carries two freeze bits. The read-freeze bit holds the copies steady so a multi-byte read is coherent. The write-freeze bit does the same and also unlocks the time fields for host writes. Clearing the write-freeze bit loads every time field into the counters on a single clock edge. The stop flag in the seconds byte and the century-enable flag in the day byte take effect as soon as they are written.

Top module: `rtc_calendar_bank`

## Requirements
- R1: The window is the eight highest addresses. By low three address bits: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. `mem_sel_o` is high exactly when `sel_i` is high and the address is below the window. `rdata_o` is 0x00 unless a read (`sel_i`=1, `we_i`=0) targets the window.
- R2: On an enabled tick, seconds count 00..59 and wrap to 00, carrying into minutes. Minutes wrap 59 to 00, carrying into hours. Hours wrap 23 to 00, carrying into day and date.
- R3: Day counts 01..07 and wraps to 01. Date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for months 01, 03, 05, 07, 08, 10 and 12. The wrap carries into month.
- R4: February ends at date 29 when the BCD year is divisible by four (year 00 included), and at 28 otherwise.
- R5: Month wraps 12 to 01, carrying into year. Year wraps 99 to 00.
- R6: While control bit 6 is 1, the holding registers keep their values as ticks arrive, and the counters keep running. One clock after the bit is cleared, the registers show the live time.
- R7: While control bit 7 is 1, the host may write the time fields. Writing control with bit 7 = 0 while it was 1 loads all seven time registers and the century bit into the counters on that clock edge, and discards any count made during the freeze.
- R8: Writes to time fields while control bit 7 is 0 have no effect on the values read back.
- R9: Seconds bit 7 is a stop flag, writable at any time. While it is 1, ticks do not advance the counters. After it is cleared, the next tick advances the seconds.
- R10: In the day register, bit 5 is the century enable and is writable at any time. Bit 4 is the century bit and is writable only while control bit 7 is 1. On a year wrap from 99 to 00, the century bit toggles if the enable is 1 and holds its value if the enable is 0.
- R11: Undefined bits read as 0 whatever was written: control bits 5..0, minutes bit 7, hours bits 7..6, day bits 7, 6 and 3, date bits 7..6, month bits 7..5.
- R12: After reset the bank reads: control 0x00, time 00:00:00, day 01, date 01, month 01, year 00. Stop, century enable and century bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 Hz advance enable |
| sel_i | input | 1 | Host access select |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data (combinational) |
| mem_sel_o | output | 1 | Select for external memory below the window |

## Verification
The range and February assertions rely on the host loading only legal BCD values into the counters. Out-of-range patterns may sit in the holding registers, but they must never be committed. The bench writes all-ones patterns only while the write-freeze bit is set, and it overwrites them with legal values before it clears that bit. The commit assertion assumes a commit is never issued in the same cycle as another window write, because the host port carries one access per cycle. Ticks are single-cycle pulses driven away from the clock edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [OFF_W-1:0] OFF_SEC  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_MIN  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_HR   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_DAY  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_DATE = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MON  = 3'd6;
  localparam logic [OFF_W-1:0] OFF_YR   = 3'd7;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic       cb;
    logic [7:0] hr;
    logic [7:0] mins;
    logic [7:0] secs;
  } cal_t;

  localparam cal_t CAL_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01, day: 8'h01,
                                 cb: 1'b0, hr: 8'h00, mins: 8'h00, secs: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  output logic [7:0] last_date_o
);
  logic leap;

  // 10 = 2 mod 4, so BCD year mod 4 = (2*tens + units) mod 4
  assign leap = ((({1'b0, yr_i[7:4], 1'b0} + {2'b00, yr_i[3:0]}) & 6'd3) == 6'd0);

  always_comb begin
    unique case (mon_i)
      8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stop_i,
  input  logic ceb_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t live_o
);
  cal_t       live_q;
  logic [7:0] last_date;
  logic       adv, c_min, c_hr, c_day, c_mon, c_yr, c_cent;
  logic       sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;

  rtc_month_len i_month_len (
    .mon_i      (live_q.mon),
    .yr_i       (live_q.yr),
    .last_date_o(last_date)
  );

  assign sec_wrap  = (live_q.secs == 8'h59);
  assign min_wrap  = (live_q.mins == 8'h59);
  assign hr_wrap   = (live_q.hr   == 8'h23);
  assign date_wrap = (live_q.date == last_date);
  assign mon_wrap  = (live_q.mon  == 8'h12);
  assign yr_wrap   = (live_q.yr   == 8'h99);

  assign adv    = tick_i && !stop_i && !load_i;
  assign c_min  = adv    && sec_wrap;
  assign c_hr   = c_min  && min_wrap;
  assign c_day  = c_hr   && hr_wrap;
  assign c_mon  = c_day  && date_wrap;
  assign c_yr   = c_mon  && mon_wrap;
  assign c_cent = c_yr   && yr_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= CAL_RESET;
    end else if (load_i) begin
      live_q <= load_val_i;
    end else if (adv) begin
      live_q.secs <= sec_wrap ? 8'h00 : bcd_inc(live_q.secs);
      if (c_min) live_q.mins <= min_wrap ? 8'h00 : bcd_inc(live_q.mins);
      if (c_hr)  live_q.hr   <= hr_wrap  ? 8'h00 : bcd_inc(live_q.hr);
      if (c_day) begin
        live_q.day  <= (live_q.day == 8'h07) ? 8'h01 : bcd_inc(live_q.day);
        live_q.date <= date_wrap ? 8'h01 : bcd_inc(live_q.date);
      end
      if (c_mon) live_q.mon <= mon_wrap ? 8'h01 : bcd_inc(live_q.mon);
      if (c_yr)  live_q.yr  <= yr_wrap  ? 8'h00 : bcd_inc(live_q.yr);
      if (c_cent && ceb_i) live_q.cb <= ~live_q.cb;
    end
  end

  assign live_o = live_q;

  a_r2_secs_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q.secs <= 8'h59);
  a_r4_feb_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q.mon == 8'h02) |-> (live_q.date <= 8'h29));
  a_r7_commit_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (live_q == $past(load_val_i)));
  a_r9_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> $stable(live_q));
  a_r10_cent_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_cent && ceb_i) |=> (live_q.cb != $past(live_q.cb)));
  a_r10_cent_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ceb_i && !load_i) |=> $stable(live_q.cb));
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       wdata_i,
  input  cal_t             live_i,
  output logic [7:0]       rdata_o,
  output logic             commit_o,
  output cal_t             hold_o,
  output logic             stop_o,
  output logic             ceb_o
);
  cal_t hold_q;
  logic wr_q, rd_q, stop_q, ceb_q;
  logic frozen, unlocked_wr;

  assign frozen      = wr_q || rd_q;
  assign unlocked_wr = wr_en_i && wr_q;
  assign commit_o    = wr_en_i && (off_i == OFF_CTRL) && wr_q && !wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      stop_q <= 1'b0;
      ceb_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (off_i == OFF_CTRL) begin
        wr_q <= wdata_i[7];
        rd_q <= wdata_i[6];
      end
      if (off_i == OFF_SEC) stop_q <= wdata_i[7];
      if (off_i == OFF_DAY) ceb_q  <= wdata_i[5];
    end
  end

  // Copies track the counters unless frozen; fields are masked on write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= CAL_RESET;
    end else if (!frozen) begin
      hold_q <= live_i;
    end else if (unlocked_wr) begin
      unique case (off_i)
        OFF_SEC:  hold_q.secs <= {1'b0, wdata_i[6:0]};
        OFF_MIN:  hold_q.mins <= {1'b0, wdata_i[6:0]};
        OFF_HR:   hold_q.hr   <= {2'b00, wdata_i[5:0]};
        OFF_DAY: begin
          hold_q.day <= {5'b00000, wdata_i[2:0]};
          hold_q.cb  <= wdata_i[4];
        end
        OFF_DATE: hold_q.date <= {2'b00, wdata_i[5:0]};
        OFF_MON:  hold_q.mon  <= {3'b000, wdata_i[4:0]};
        OFF_YR:   hold_q.yr   <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_en_i) begin
      unique case (off_i)
        OFF_CTRL: rdata_o = {wr_q, rd_q, 6'b000000};
        OFF_SEC:  rdata_o = hold_q.secs | {stop_q, 7'b0000000};
        OFF_MIN:  rdata_o = hold_q.mins;
        OFF_HR:   rdata_o = hold_q.hr;
        OFF_DAY:  rdata_o = hold_q.day | {2'b00, ceb_q, hold_q.cb, 4'b0000};
        OFF_DATE: rdata_o = hold_q.date;
        OFF_MON:  rdata_o = hold_q.mon;
        default:  rdata_o = hold_q.yr;
      endcase
    end
  end

  assign hold_o = hold_q;
  assign stop_o = stop_q;
  assign ceb_o  = ceb_q;

  a_r6_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && !wr_en_i) |=> $stable(hold_q));
  a_r8_unlocked_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen |=> (hold_q == $past(live_i)));
  a_r11_ctrl_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && off_i == OFF_CTRL) |-> (rdata_o[5:0] == 6'd0));
endmodule

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              mem_sel_o
);
  localparam int unsigned WIN_TOP = ADDR_W - 1;

  logic             in_win, wr_en, rd_en, commit, stop, ceb;
  logic [OFF_W-1:0] off;
  cal_t             live, hold;

  assign in_win    = &addr_i[WIN_TOP:OFF_W];
  assign off       = addr_i[OFF_W-1:0];
  assign wr_en     = sel_i && we_i && in_win;
  assign rd_en     = sel_i && !we_i && in_win;
  assign mem_sel_o = sel_i && !in_win;

  rtc_shadow_bank i_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .off_i   (off),
    .wdata_i (wdata_i),
    .live_i  (live),
    .rdata_o (rdata_o),
    .commit_o(commit),
    .hold_o  (hold),
    .stop_o  (stop),
    .ceb_o   (ceb)
  );

  rtc_time_chain i_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .stop_i    (stop),
    .ceb_i     (ceb),
    .load_i    (commit),
    .load_val_i(hold),
    .live_o    (live)
  );

  a_r1_decode_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_sel_o && (rd_en || wr_en)));
  a_r1_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |-> (rdata_o == 8'h00));
endmodule

// File: tb/test_rtc_calendar_bank.sv
module test_rtc_calendar_bank;
  localparam int unsigned ADDR_W = 15;
  localparam logic [ADDR_W-1:0] WIN = 15'h7FF8;

  logic              clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, sel = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0, rdata;
  logic              mem_sel;
  int                checks = 0, errors = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar_bank #(.ADDR_W(ADDR_W)) i_rtc_calendar_bank (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .mem_sel_o(mem_sel));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = WIN + ADDR_W'(off); wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = WIN + ADDR_W'(off);
    #1 check(tag, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dt, dy, hr, mi, se);
    wr(3'd0, 8'h80);
    wr(3'd1, se); wr(3'd2, mi); wr(3'd3, hr); wr(3'd4, dy);
    wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, yr);
    wr(3'd0, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reg(3'd0, 8'h00, "R12 ctrl"); chk_reg(3'd1, 8'h00, "R12 sec");
    chk_reg(3'd2, 8'h00, "R12 min");  chk_reg(3'd3, 8'h00, "R12 hr");
    chk_reg(3'd4, 8'h01, "R12 day");  chk_reg(3'd5, 8'h01, "R12 date");
    chk_reg(3'd6, 8'h01, "R12 mon");  chk_reg(3'd7, 8'h00, "R12 yr");
  endtask

  task automatic t_decode;
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = 15'h0123;
    #1 check("R1 mem_sel low addr", {7'd0, mem_sel}, 8'h01);
    check("R1 rdata outside window", rdata, 8'h00);
    addr = 15'h7FF7;
    #1 check("R1 mem_sel just below", {7'd0, mem_sel}, 8'h01);
    addr = WIN;
    #1 check("R1 mem_sel in window", {7'd0, mem_sel}, 8'h00);
    sel = 1'b0;
    #1 check("R1 mem_sel idle", {7'd0, mem_sel}, 8'h00);
  endtask

  task automatic t_basic;
    set_time(8'h25, 8'h03, 8'h10, 8'h02, 8'h08, 8'h15, 8'h58);
    do_tick(1);
    chk_reg(3'd1, 8'h59, "R2 sec inc");
    do_tick(1);
    chk_reg(3'd1, 8'h00, "R2 sec wrap"); chk_reg(3'd2, 8'h16, "R2 min carry");
  endtask

  task automatic t_cascade;
    set_time(8'h99, 8'h12, 8'h31, 8'h27, 8'h23, 8'h59, 8'h59); // ceb=1 cb=0 day 7
    do_tick(1);
    chk_reg(3'd1, 8'h00, "R2 sec"); chk_reg(3'd2, 8'h00, "R2 min");
    chk_reg(3'd3, 8'h00, "R2 hr");  chk_reg(3'd4, 8'h31, "R3/R10 day wrap, cb toggled");
    chk_reg(3'd5, 8'h01, "R3 date"); chk_reg(3'd6, 8'h01, "R5 mon");
    chk_reg(3'd7, 8'h00, "R5 yr");
    set_time(8'h99, 8'h12, 8'h31, 8'h13, 8'h23, 8'h59, 8'h59); // ceb=0 cb=1
    do_tick(1);
    chk_reg(3'd4, 8'h14, "R10 cb held with enable off");
  endtask

  task automatic t_months;
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    do_tick(1);
    chk_reg(3'd5, 8'h29, "R4 leap 24 date"); chk_reg(3'd6, 8'h02, "R4 leap 24 mon");
    set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    do_tick(1);
    chk_reg(3'd5, 8'h01, "R4 non-leap 23 date"); chk_reg(3'd6, 8'h03, "R4 non-leap mon");
    set_time(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    do_tick(1);
    chk_reg(3'd5, 8'h29, "R4 leap 00");
    set_time(8'h10, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    do_tick(1);
    chk_reg(3'd5, 8'h01, "R4 non-leap 10");
    set_time(8'h21, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    do_tick(1);
    chk_reg(3'd5, 8'h01, "R3 30-day wrap"); chk_reg(3'd6, 8'h05, "R3 month after Apr");
    set_time(8'h21, 8'h07, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    do_tick(1);
    chk_reg(3'd5, 8'h31, "R3 31-day month"); chk_reg(3'd4, 8'h06, "R3 day inc");
  endtask

  task automatic t_read_freeze;
    set_time(8'h30, 8'h06, 8'h15, 8'h01, 8'h10, 8'h20, 8'h10);
    wr(3'd0, 8'h40);
    do_tick(3);
    chk_reg(3'd1, 8'h10, "R6 frozen sec");
    chk_reg(3'd0, 8'h40, "R6 ctrl readback");
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk_reg(3'd1, 8'h13, "R6 live after release");
  endtask

  task automatic t_commit;
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h05); wr(3'd2, 8'h44);
    do_tick(4);
    chk_reg(3'd1, 8'h05, "R7 held during write freeze");
    wr(3'd3, 8'h17);
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk_reg(3'd1, 8'h05, "R7 commit sec"); chk_reg(3'd2, 8'h44, "R7 commit min");
    chk_reg(3'd3, 8'h17, "R7 commit hr");
  endtask

  task automatic t_ignored;
    set_time(8'h30, 8'h06, 8'h15, 8'h01, 8'h10, 8'h20, 8'h10);
    wr(3'd1, 8'h33); wr(3'd7, 8'h55);
    chk_reg(3'd1, 8'h10, "R8 sec write ignored");
    chk_reg(3'd7, 8'h30, "R8 yr write ignored");
    wr(3'd4, 8'h31); // ceb=1 taken, cb=1 dropped
    chk_reg(3'd4, 8'h21, "R10 ceb free, cb locked");
  endtask

  task automatic t_stop;
    set_time(8'h30, 8'h06, 8'h15, 8'h01, 8'h10, 8'h20, 8'h10);
    wr(3'd1, 8'h80);
    do_tick(2);
    chk_reg(3'd1, 8'h90, "R9 stopped");
    wr(3'd1, 8'h00);
    do_tick(1);
    chk_reg(3'd1, 8'h11, "R9 resumes");
  endtask

  task automatic t_reserved;
    wr(3'd0, 8'hBF);
    chk_reg(3'd0, 8'h80, "R11 ctrl");
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hDF);
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    chk_reg(3'd2, 8'h7F, "R11 min");  chk_reg(3'd3, 8'h3F, "R11 hr");
    chk_reg(3'd4, 8'h17, "R11 day");  chk_reg(3'd5, 8'h3F, "R11 date");
    chk_reg(3'd6, 8'h1F, "R11 mon");
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h01);
    wr(3'd5, 8'h01); wr(3'd6, 8'h01);
    wr(3'd0, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_decode();
    t_basic();
    t_cascade();
    t_months();
    t_read_freeze();
    t_commit();
    t_ignored();
    t_stop();
    t_reserved();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule